// File: doc/BRIEF.md
# Keyed Flash Program and Erase Controller

This block sits on a simple register bus and performs single-word program and whole-page erase operations on a behavioural flash array held inside it. Software picks an operation code and a target byte address, and for a program it also supplies a data word. It sets the write-enable bit, writes a fixed three-word key sequence to a dedicated key register, and then sets the start bit. The start bit stays high for a parameterised number of cycles, then clears itself. Software polls that bit to learn when the array has been updated.

Starts that are not properly authorised raise a sticky write-error flag and leave the array untouched. A start is unauthorised when write-enable is clear, when the key sequence is incomplete or out of order, or when the operation code is not one of the two supported codes. A low-voltage input that rises during an operation aborts it and raises a sticky low-voltage flag. Every register accepts plain, OR-in and AND-out writes, so single fields can be changed without a read-modify-write. A side read port exposes the array contents to the surrounding logic.

Top module: `flash_keyed_ctrl`

## Requirements
- R1: After reset the control, key, address and data registers read 0, write-enable is clear, and every array word reads 0xFFFFFFFF.
- R2: The register is selected by `bus_addr[3:2]`: 0 control, 1 key, 2 address, 3 data. The alias is selected by `bus_addr[1:0]`: 1 ORs the written ones into the register, 2 clears the written ones, and 0 or 3 replaces the value. The key register always reads 0, so a clear-alias write presents the key value 0. Control fields are: operation code in bits 3:0, low-voltage error in bit 12, write error in bit 13, write-enable in bit 14, and start/busy in bit 15. All other bits read 0.
- R3: Writing the key values 0x00000000, 0xAA996655 and 0x556699AA in that order arms the block. A control write whose resulting start bit is 1 then begins the operation, provided write-enable is 1 and the code is 1 (program) or 4 (erase). Writing 0 to the key at any point restarts the sequence.
- R4: A key write that breaks the order returns the sequence to idle. Any start attempt, whether successful or not, consumes the armed state, so a second start with no new key sequence sets the write-error flag.
- R5: A start attempt with write-enable 0 sets the write-error flag, leaves the start bit 0, and does not change the array.
- R6: The start bit reads 1 for exactly PROG_CYC cycles after a program start, or ERASE_CYC cycles after an erase start, and then returns to 0 by itself.
- R7: At completion, a program stores the old word ANDed with the data register. The target is the word whose index is address bits [AW+1:2]. Higher address bits are ignored.
- R8: At completion, an erase sets every word of the page selected by address bits [AW+1:PW+2] to 0xFFFFFFFF. Words outside that page keep their values.
- R9: If `lowv_in` is 1 in a cycle while busy, the operation ends at that edge, the low-voltage flag is set, and the array is unchanged. When the block is idle, `lowv_in` has no effect.
- R10: Both error flags stay set through plain and OR-in writes. They clear only through a clear-alias write with their bit set.
- R11: While busy, writes to the control, address and data registers are ignored.
- R12: A properly armed and enabled start with an operation code other than 1 or 4 sets the write-error flag and starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select [3:2] and alias select [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| lowv_in | input | 1 | Low-voltage event input |
| mem_raddr | input | $clog2(WORDS) | Array word index for the side read port |
| mem_rdata | output | 32 | Array word at mem_raddr |

## Verification
The cycle assertions cover several rules on every cycle. Busy only rises after the armed state. Busy only falls when the counter expires or a low-voltage abort occurs. A low-voltage abort always lands on the next edge. The array never changes while idle. Error flags fall only after a clear-alias write, and the address and data registers hold while busy. The exact busy length, the AND-merge result of a program, the page boundaries of an erase, the alias arithmetic and the effect of broken or reused key sequences depend on stimulus history. Only the bench scenarios, with a reference array model, can show these.

// File: rtl/flash_keyed_ctrl.sv
module flash_keyed_ctrl #(
  parameter int WORDS      = 256,
  parameter int PAGE_WORDS = 16,
  parameter int PROG_CYC   = 8,
  parameter int ERASE_CYC  = 64,
  parameter logic [31:0] KEY_A = 32'hAA99_6655,
  parameter logic [31:0] KEY_B = 32'h5566_99AA
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [3:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     lowv_in,
  input  logic [$clog2(WORDS)-1:0] mem_raddr,
  output logic [31:0]              mem_rdata
);
  localparam int AW    = $clog2(WORDS);
  localparam int PW    = $clog2(PAGE_WORDS);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW    = $clog2(MAXC);
  localparam logic [3:0] OP_PROG  = 4'd1;
  localparam logic [3:0] OP_ERASE = 4'd4;

  typedef enum logic [1:0] {K_IDLE, K_ZERO, K_ONE, K_OPEN} key_t;

  logic        busy_q, wren_q, wrerr_q, lverr_q;
  logic [3:0]  op_q;
  logic [31:0] addr_q, data_q;
  key_t        key_q, key_next;
  logic [CW-1:0] cnt_q;
  logic [31:0] mem [WORDS];

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] w,
                                        input logic s, input logic c);
    return c ? (cur & ~w) : (s ? (cur | w) : w);
  endfunction

  wire is_set  = bus_addr[1:0] == 2'd1;
  wire is_clr  = bus_addr[1:0] == 2'd2;
  wire ctrl_wr = bus_we && bus_addr[3:2] == 2'd0 && !busy_q;
  wire key_wr  = bus_we && bus_addr[3:2] == 2'd1;
  wire addr_wr = bus_we && bus_addr[3:2] == 2'd2 && !busy_q;
  wire data_wr = bus_we && bus_addr[3:2] == 2'd3 && !busy_q;

  wire [3:0] nv_op   = is_clr ? (op_q & ~bus_wdata[3:0]) : is_set ? (op_q | bus_wdata[3:0]) : bus_wdata[3:0];
  wire       nv_wren = is_clr ? (wren_q & ~bus_wdata[14]) : is_set ? (wren_q | bus_wdata[14]) : bus_wdata[14];
  wire       nv_go   = !is_clr && bus_wdata[15];

  wire start_try = ctrl_wr && nv_go;
  wire start_ok  = start_try && nv_wren && key_q == K_OPEN && (nv_op == OP_PROG || nv_op == OP_ERASE);
  wire abort     = busy_q && lowv_in;
  wire done      = busy_q && !lowv_in && cnt_q == '0;
  wire clr_wrerr = ctrl_wr && is_clr && bus_wdata[13];
  wire clr_lverr = ctrl_wr && is_clr && bus_wdata[12];

  wire [31:0]   key_nv = is_clr ? 32'd0 : bus_wdata;
  wire [AW-1:0] wix    = addr_q[AW+1:2];

  always_comb begin
    if (key_nv == 32'd0)                      key_next = K_ZERO;
    else if (key_q == K_ZERO && key_nv == KEY_A) key_next = K_ONE;
    else if (key_q == K_ONE && key_nv == KEY_B)  key_next = K_OPEN;
    else                                      key_next = K_IDLE;
  end

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = {16'd0, busy_q, wren_q, wrerr_q, lverr_q, 8'd0, op_q};
      2'd1:    bus_rdata = 32'd0;
      2'd2:    bus_rdata = addr_q;
      default: bus_rdata = data_q;
    endcase
  end

  assign mem_rdata = mem[mem_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wren_q <= 1'b0; wrerr_q <= 1'b0; lverr_q <= 1'b0;
      op_q <= '0; addr_q <= '0; data_q <= '0; key_q <= K_IDLE; cnt_q <= '0;
    end else begin
      if (addr_wr) addr_q <= merge(addr_q, bus_wdata, is_set, is_clr);
      if (data_wr) data_q <= merge(data_q, bus_wdata, is_set, is_clr);
      if (key_wr) key_q <= key_next;
      else if (start_try) key_q <= K_IDLE;
      if (ctrl_wr) begin
        op_q   <= nv_op;
        wren_q <= nv_wren;
      end
      if (start_try && !start_ok) wrerr_q <= 1'b1;
      else if (clr_wrerr)         wrerr_q <= 1'b0;
      if (abort)          lverr_q <= 1'b1;
      else if (clr_lverr) lverr_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= (nv_op == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
      end else if (abort || done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (done) begin
      if (op_q == OP_PROG) mem[wix] <= mem[wix] & data_q;
      else
        for (int i = 0; i < WORDS; i++)
          if ((i / PAGE_WORDS) == int'(addr_q[AW+1:PW+2])) mem[i] <= '1;
    end
  end

  assert_armed_before_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(key_q) == K_OPEN);

  assert_busy_ends_legally_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0 || $past(lowv_in)));

  assert_lowv_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && lowv_in) |=> (!busy_q && lverr_q));

  assert_array_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy_q) && $stable(mem_raddr)) |-> $stable(mem_rdata));

  assert_wrerr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wrerr_q) |-> $past(bus_we && bus_addr == 4'b0010 && bus_wdata[13]));

  assert_frozen_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: tb/flash_keyed_ctrl_tb.sv
module flash_keyed_ctrl_tb;
  localparam logic [1:0] RC = 2'd0, RK = 2'd1, RA = 2'd2, RD = 2'd3;
  localparam logic [1:0] WRAW = 2'd0, WSET = 2'd1, WCLR = 2'd2;
  localparam logic [31:0] KA = 32'hAA99_6655, KB = 32'h5566_99AA;

  logic clk = 0, rst_n = 0, bus_we = 0, lowv_in = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, mem_rdata;
  logic [7:0] mem_raddr = '0;
  logic [31:0] exp_mem [256];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  flash_keyed_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lowv_in(lowv_in),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  function automatic logic [31:0] cw(input bit b, input bit we, input bit e1, input bit e0, input logic [3:0] op);
    return {16'd0, b, we, e1, e0, 8'd0, op};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = {r, a}; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] r, output logic [31:0] v);
    bus_addr = {r, 2'd0}; #1; v = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [1:0] r, input logic [31:0] exp);
    logic [31:0] v;
    rd(r, v); chk(req, v, exp);
  endtask

  task automatic mchk(input string req, input int w);
    mem_raddr = 8'(w); #1; chk(req, mem_rdata, exp_mem[w]);
  endtask

  task automatic unlock();
    wr(RK, WRAW, 32'd0); wr(RK, WRAW, KA); wr(RK, WRAW, KB);
  endtask

  task automatic go(input logic [3:0] op, input int w, input logic [31:0] d);
    wr(RA, WRAW, 32'(w * 4)); wr(RD, WRAW, d); wr(RC, WRAW, 32'h4000 | 32'(op));
    unlock(); wr(RC, WSET, 32'h8000);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int k = 0;
    rd(RC, v);
    while (v[15] && k < 200) begin @(negedge clk); rd(RC, v); k++; end
    chk(req, 32'(v[15]), 32'd0);
  endtask

  task automatic run_len(input string req, input int dur);
    logic [31:0] v;
    rd(RC, v); chk(req, 32'(v[15]), 32'd1);
    repeat (dur - 1) @(negedge clk);
    rd(RC, v); chk(req, 32'(v[15]), 32'd1);
    @(negedge clk);
    rd(RC, v); chk(req, 32'(v[15]), 32'd0);
  endtask

  function automatic void m_prog(input int w, input logic [31:0] d);
    exp_mem[w] = exp_mem[w] & d;
  endfunction

  function automatic void m_erase(input int w);
    for (int i = 0; i < 256; i++) if (i / 16 == w / 16) exp_mem[i] = '1;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) exp_mem[i] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rchk("R1 ctrl", RC, 32'd0); rchk("R1 key", RK, 32'd0); rchk("R1 addr", RA, 32'd0);
    rchk("R1 data", RD, 32'd0); mchk("R1 mem0", 0); mchk("R1 mem255", 255);
    // R2
    wr(RA, WRAW, 32'h1234_5678); wr(RA, WSET, 32'h0000_0F00); rchk("R2 addr set", RA, 32'h1234_5F78);
    wr(RA, WCLR, 32'h1200_0000); rchk("R2 addr clr", RA, 32'h0034_5F78);
    wr(RD, WRAW, 32'hA5A5_A5A5); wr(RD, WCLR, 32'h0000_FFFF); rchk("R2 data clr", RD, 32'hA5A5_0000);
    wr(RD, WSET, 32'h0000_000F); rchk("R2 data set", RD, 32'hA5A5_000F);
    wr(RC, WSET, 32'h4004); rchk("R2 ctrl set", RC, 32'h4004);
    wr(RC, WCLR, 32'h0004); rchk("R2 ctrl clr", RC, 32'h4000);
    wr(RC, WRAW, 32'h0001); rchk("R2 ctrl raw", RC, 32'h0001);
    wr(RK, WSET, 32'hFFFF); rchk("R2 key reads zero", RK, 32'd0);
    // R3 R6 R7
    go(4'd1, 5, 32'hF0F0_1234); run_len("R6 program length", 8);
    m_prog(5, 32'hF0F0_1234); mchk("R7 program", 5); rchk("R3 ctrl after", RC, cw(0, 1, 0, 0, 4'd1));
    go(4'd1, 5 + 256, 32'h0FFF_00FF); wait_idle("R6 program done");
    m_prog(5, 32'h0FFF_00FF); mchk("R7 and-merge high bits ignored", 5);
    // R8
    go(4'd1, 33, 32'd0); wait_idle("R6"); m_prog(33, 0);
    go(4'd1, 48, 32'h1234_5678); wait_idle("R6"); m_prog(48, 32'h1234_5678);
    go(4'd4, 40, 32'd0); run_len("R6 erase length", 64); m_erase(40);
    mchk("R8 erased 32", 32); mchk("R8 erased 33", 33); mchk("R8 erased 47", 47); mchk("R8 kept 48", 48);
    rchk("R8 ctrl", RC, cw(0, 1, 0, 0, 4'd4));
    // R5
    wr(RC, WCLR, 32'h4000); wr(RC, WRAW, 32'h0001); wr(RA, WRAW, 32'(48 * 4)); wr(RD, WRAW, 32'd0);
    unlock(); wr(RC, WSET, 32'h8000);
    rchk("R5 wren off", RC, cw(0, 0, 1, 0, 4'd1)); mchk("R5 array untouched", 48);
    // R10
    wr(RC, WRAW, 32'h4001); rchk("R10 raw keeps", RC, cw(0, 1, 1, 0, 4'd1));
    wr(RC, WSET, 32'h0000); rchk("R10 set keeps", RC, cw(0, 1, 1, 0, 4'd1));
    wr(RC, WCLR, 32'h2000); rchk("R10 clr clears", RC, cw(0, 1, 0, 0, 4'd1));
    // R4
    wr(RK, WRAW, 32'd0); wr(RK, WRAW, KA); wr(RK, WRAW, KA); wr(RK, WRAW, KB);
    wr(RC, WSET, 32'h8000); rchk("R4 broken order", RC, cw(0, 1, 1, 0, 4'd1)); mchk("R4 untouched", 48);
    wr(RC, WCLR, 32'h2000);
    unlock(); wr(RC, WSET, 32'h8000); wait_idle("R4 ok start"); m_prog(48, 0); mchk("R4 programmed", 48);
    wr(RC, WSET, 32'h8000); rchk("R4 unlock consumed", RC, cw(0, 1, 1, 0, 4'd1));
    wr(RC, WCLR, 32'h2000);
    wr(RK, WRAW, 32'd0); wr(RK, WRAW, KA); wr(RK, WRAW, 32'd0); wr(RK, WRAW, KA); wr(RK, WRAW, KB);
    wr(RC, WSET, 32'h8000); rchk("R3 restart by zero", RC, cw(1, 1, 0, 0, 4'd1)); wait_idle("R3");
    // R12
    wr(RC, WRAW, 32'h4002); unlock(); wr(RC, WSET, 32'h8000);
    rchk("R12 bad op", RC, cw(0, 1, 1, 0, 4'd2)); wr(RC, WCLR, 32'h2000);
    // R11
    go(4'd1, 66, 32'd0); wait_idle("R6"); m_prog(66, 0);
    go(4'd4, 70, 32'h0BAD_F00D);
    wr(RA, WRAW, 32'd0); wr(RD, WRAW, 32'hDEAD); wr(RC, WCLR, 32'h4000);
    rchk("R11 ctrl held", RC, cw(1, 1, 0, 0, 4'd4));
    rchk("R11 addr held", RA, 32'd280); rchk("R11 data held", RD, 32'h0BAD_F00D);
    wait_idle("R11 done"); m_erase(70); mchk("R11 erase used held addr", 66);
    rchk("R11 wren kept", RC, cw(0, 1, 0, 0, 4'd4));
    // R9
    go(4'd4, 5, 32'd0);
    @(negedge clk); lowv_in = 1; @(negedge clk); lowv_in = 0;
    rchk("R9 abort", RC, cw(0, 1, 0, 1, 4'd4)); mchk("R9 array unchanged", 5);
    wr(RC, WCLR, 32'h1000); rchk("R9 clear lv", RC, cw(0, 1, 0, 0, 4'd4));
    @(negedge clk); lowv_in = 1; @(negedge clk); lowv_in = 0;
    rchk("R9 idle ignored", RC, cw(0, 1, 0, 0, 4'd4));
    // random mix
    for (int it = 0; it < 30; it++) begin
      int w = int'($urandom_range(0, 255));
      logic [31:0] d = $urandom;
      int kind = int'($urandom_range(0, 3));
      if (kind == 0) begin
        go(4'd4, w, d); wait_idle("R6 rnd"); m_erase(w);
        mchk("R8 rnd", w); mchk("R8 rnd base", (w / 16) * 16);
      end else if (kind == 3) begin
        wr(RA, WRAW, 32'(w * 4)); wr(RD, WRAW, 32'd0); wr(RC, WRAW, 32'h4001);
        wr(RK, WRAW, 32'd0); wr(RK, WRAW, KA ^ 32'h1); wr(RK, WRAW, KB); wr(RC, WSET, 32'h8000);
        rchk("R4 rnd", RC, cw(0, 1, 1, 0, 4'd1)); mchk("R4 rnd untouched", w);
        wr(RC, WCLR, 32'h2000);
      end else begin
        go(4'd1, w, d); wait_idle("R6 rnd"); m_prog(w, d); mchk("R7 rnd", w);
      end
    end
    summary();
  end
endmodule